// File: doc/BRIEF.md
# Synthesizer Power-Down Controller

This block decides when a frequency synthesizer is held in power-down and when it may run. It watches the chip-enable pin, two programmed control bits (a power-down request bit and a mode bit that selects deferred entry), a strobe marking each charge pump event, and the reset pulse issued when the initialization word is loaded. From these it drives one power-down level and three forcing lines. The forcing lines hold the counters at their load point, put the charge pump in three-state and clear the clock-detect logic.

Chip enable low shuts the device down at once, through a combinational path, whatever the programmed bits hold. In immediate mode, a write that sets the request bit takes effect on the next clock. In deferred mode, the request waits in a pending state until the next charge pump event, so the loop is never disturbed partway through a correction. An initialization pulse that arrives while deferred mode is programmed and chip enable is high starts power-down straight away. The configuration register takes writes at all times and presents the bits it holds on its outputs. Leaving power-down needs chip enable high, after a synchronizer of `SYNC_STAGES` flops, and the request bit clear.

Top module: `pd_ctrl`

## Requirements
- R1: While `chip_en` is 0, `pd_active`, `force_load`, `cp_tristate` and `clkdet_reset` are 1 in the same cycle, with no clock edge needed.
- R2: A write (`cfg_we`=1) with `cfg_pd_en`=1 and `cfg_pd_sync`=0 makes `pd_active` 1 after the next rising clock edge.
- R3: A write with `cfg_pd_en`=1 and `cfg_pd_sync`=1, and no `init_pulse`, sets `pd_pending` after the next edge, and `pd_active` stays 0 while no charge pump event arrives. A `cp_event` in the same cycle as that write does not count.
- R4: While `pd_pending` is 1 and no write occurs, a `cp_event` makes `pd_active` 1 and `pd_pending` 0 after the next edge.
- R5: `force_load`, `cp_tristate` and `clkdet_reset` are each 1 exactly when `pd_active` is 1.
- R6: Configuration writes are taken in every state, including power-down. `pd_en_q` and `pd_sync_q` show the written bits after the edge.
- R7: An `init_pulse` while deferred mode is in effect and the synchronized chip enable is high makes `pd_active` 1 after the next edge, with no charge pump event.
- R8: A write with `cfg_pd_en`=0 while `pd_pending` is 1 cancels the request: `pd_pending` is 0 after the edge and `pd_active` stays 0.
- R9: In programmed power-down with chip enable synchronized high, a write with `cfg_pd_en`=0 clears `pd_active` after the next edge. When `chip_en` rises with nothing programmed, `pd_active` falls after `SYNC_STAGES` (default 2) edges.
- R10: While reset is held and in the cycle after it: the configuration bits read 0, `pd_pending` is 0 and `pd_active` is 1.
- R11: With the request bit 0, `cp_event` and `init_pulse` have no effect on `pd_active` or `pd_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_en | input | 1 | Chip-enable pin; low forces power-down |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pd_en | input | 1 | Power-down request bit to write |
| cfg_pd_sync | input | 1 | Mode bit to write: 1 deferred, 0 immediate |
| cp_event | input | 1 | Single-cycle charge pump event strobe |
| init_pulse | input | 1 | Initialization reset pulse |
| pd_active | output | 1 | Device in power-down |
| pd_pending | output | 1 | Deferred request waiting for a charge pump event |
| force_load | output | 1 | Hold counters and timeout counter at load state |
| cp_tristate | output | 1 | Charge pump forced to three-state |
| clkdet_reset | output | 1 | Clock-detect logic held in reset |
| pd_en_q | output | 1 | Latched request bit |
| pd_sync_q | output | 1 | Latched mode bit |

## Verification
On every cycle the assertions check that chip enable low forces all the forcing lines, that immediate writes and charge pump events in the pending state lead to power-down one edge later, that cancelling clears the pending flag, and that writes reach the register outputs. Only the bench scenarios show the timing of release through the synchronizer, the rule that a charge pump event in the same cycle as a deferred write is ignored, that initialization pulses trigger entry only in deferred mode, and the exact point at which programmed power-down is left.

// File: rtl/pd_ctrl_pkg.sv
package pd_ctrl_pkg;
  typedef enum logic [1:0] {
    PD_RUN  = 2'd0,
    PD_WAIT = 2'd1,
    PD_DOWN = 2'd2
  } pd_state_t;

  typedef struct packed {
    logic en;
    logic sync;
  } pd_cfg_t;
endpackage

// File: rtl/pd_cfg_latch.sv
module pd_cfg_latch
  import pd_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  pd_cfg_t wdata,
  output pd_cfg_t q,
  output pd_cfg_t eff
);
  pd_cfg_t q_r;
  pd_cfg_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (we) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (we) q_r <= q_nxt;
  end

  // Bits in force this cycle: a write takes effect in the same cycle it is latched
  assign eff = we ? wdata : q_r;
  assign q   = q_r;
endmodule

// File: rtl/pd_ce_sync.sv
module pd_ce_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  generate
    if (STAGES <= 1) begin : g_single
      logic s_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_r <= 1'b0;
        else        s_r <= async_in;
      end
      assign sync_out = s_r;
    end else begin : g_chain
      logic [LAST:0] s_r;
      logic [LAST:0] s_nxt;
      always_comb s_nxt = {s_r[LAST-1:0], async_in};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_r <= '0;
        else        s_r <= s_nxt;
      end
      assign sync_out = s_r[LAST];
    end
  endgenerate
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_ok,
  input  logic      wr,
  input  pd_cfg_t   eff,
  input  logic      cp_event,
  input  logic      init_pulse,
  output pd_state_t state
);
  pd_state_t st_r;
  pd_state_t st_nxt;
  logic      init_trig;

  assign init_trig = init_pulse & ce_ok;

  always_comb begin
    st_nxt = st_r;
    unique case (st_r)
      PD_RUN: begin
        if (eff.en) begin
          if (!eff.sync)      st_nxt = PD_DOWN;
          else if (init_trig) st_nxt = PD_DOWN;
          else if (wr)        st_nxt = PD_WAIT;
        end
      end
      PD_WAIT: begin
        if (!eff.en)                       st_nxt = PD_RUN;
        else if (!eff.sync)                st_nxt = PD_DOWN;
        else if (init_trig)                st_nxt = PD_DOWN;
        else if (cp_event && !wr)          st_nxt = PD_DOWN;
      end
      PD_DOWN: begin
        if (!eff.en && ce_ok) st_nxt = PD_RUN;
      end
      default: st_nxt = PD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_r <= PD_RUN;
    else        st_r <= st_nxt;
  end

  assign state = st_r;
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic cfg_we,
  input  logic cfg_pd_en,
  input  logic cfg_pd_sync,
  input  logic cp_event,
  input  logic init_pulse,
  output logic pd_active,
  output logic pd_pending,
  output logic force_load,
  output logic cp_tristate,
  output logic clkdet_reset,
  output logic pd_en_q,
  output logic pd_sync_q
);
  pd_cfg_t   wdata;
  pd_cfg_t   cfg_q;
  pd_cfg_t   cfg_eff;
  logic      ce_sync;
  pd_state_t state;
  logic      pd_any;

  assign wdata.en   = cfg_pd_en;
  assign wdata.sync = cfg_pd_sync;

  pd_cfg_latch u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (wdata),
    .q     (cfg_q),
    .eff   (cfg_eff)
  );

  pd_ce_sync #(.STAGES(SYNC_STAGES)) u_ce (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (chip_en),
    .sync_out (ce_sync)
  );

  pd_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_ok      (ce_sync),
    .wr         (cfg_we),
    .eff        (cfg_eff),
    .cp_event   (cp_event),
    .init_pulse (init_pulse),
    .state      (state)
  );

  // Raw pin gives immediate entry; synchronized copy governs release
  assign pd_any = ~chip_en | ~ce_sync | (state == PD_DOWN);

  assign pd_active    = pd_any;
  assign force_load   = pd_any;
  assign cp_tristate  = pd_any;
  assign clkdet_reset = pd_any;
  assign pd_pending   = (state == PD_WAIT);
  assign pd_en_q      = cfg_q.en;
  assign pd_sync_q    = cfg_q.sync;
endmodule

// File: rtl/pd_ctrl_chk.sv
module pd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic cfg_we,
  input logic cfg_pd_en,
  input logic cfg_pd_sync,
  input logic cp_event,
  input logic init_pulse,
  input logic pd_active,
  input logic pd_pending,
  input logic force_load,
  input logic cp_tristate,
  input logic clkdet_reset,
  input logic pd_en_q,
  input logic pd_sync_q
);
  assert_ce_low_forces_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (force_load && cp_tristate && clkdet_reset));

  assert_async_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_pd_en && !cfg_pd_sync) |=> pd_active);

  assert_sync_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_pd_en && cfg_pd_sync && !init_pulse && !pd_active) |=> pd_pending);

  assert_cp_event_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_pending && cp_event && !cfg_we) |=> (pd_active && !pd_pending));

  assert_reg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ((pd_en_q == $past(cfg_pd_en)) && (pd_sync_q == $past(cfg_pd_sync))));

  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_pending && cfg_we && !cfg_pd_en) |=> !pd_pending);
endmodule

bind pd_ctrl pd_ctrl_chk u_chk (.*);

// File: tb/pd_ctrl_tb.sv
`timescale 1ns/1ps
module pd_ctrl_tb;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rst_n, chip_en, cfg_we, cfg_pd_en, cfg_pd_sync, cp_event, init_pulse;
  logic pd_active, pd_pending, force_load, cp_tristate, clkdet_reset, pd_en_q, pd_sync_q;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_we(cfg_we),
    .cfg_pd_en(cfg_pd_en), .cfg_pd_sync(cfg_pd_sync), .cp_event(cp_event),
    .init_pulse(init_pulse), .pd_active(pd_active), .pd_pending(pd_pending),
    .force_load(force_load), .cp_tristate(cp_tristate), .clkdet_reset(clkdet_reset),
    .pd_en_q(pd_en_q), .pd_sync_q(pd_sync_q)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic write(input logic en, input logic sy);
    cfg_we = 1'b1; cfg_pd_en = en; cfg_pd_sync = sy;
    edge1();
    cfg_we = 1'b0;
  endtask

  task automatic release_ce();
    chip_en = 1'b1;
    for (int i = 0; i < SYNC_STAGES + 1; i++) edge1();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chip_en = 1'b0; cfg_we = 1'b0; cfg_pd_en = 1'b0;
    cfg_pd_sync = 1'b0; cp_event = 1'b0; init_pulse = 1'b0;
    edge1(); edge1();
    chk("R10 reset regs", {2'b00, pd_en_q, pd_sync_q}, 4'b0000);
    chk("R10 reset pending/active", {2'b00, pd_pending, pd_active}, 4'b0001);
    rst_n = 1'b1;
    edge1();
    chk("R10 after reset", {pd_active, pd_pending, pd_en_q, pd_sync_q}, 4'b1000);
  endtask

  task automatic t_ce_rise();
    chip_en = 1'b1;
    edge1();
    chk("R9 ce sync stage 1", {3'b000, pd_active}, 4'b0001);
    edge1();
    chk("R9 ce released", {3'b000, pd_active}, 4'b0000);
    chk("R5 forces low", {1'b0, force_load, cp_tristate, clkdet_reset}, 4'b0000);
  endtask

  task automatic t_idle_cp();
    cp_event = 1'b1; init_pulse = 1'b1;
    edge1();
    cp_event = 1'b0; init_pulse = 1'b0;
    edge1();
    chk("R11 strobes ignored", {2'b00, pd_active, pd_pending}, 4'b0000);
  endtask

  task automatic t_async();
    write(1'b1, 1'b0);
    chk("R2 async entry", {2'b00, pd_active, pd_pending}, 4'b0010);
    chk("R5 forces high", {1'b0, force_load, cp_tristate, clkdet_reset}, 4'b0111);
    write(1'b0, 1'b0);
    chk("R9 programmed exit", {3'b000, pd_active}, 4'b0000);
  endtask

  task automatic t_sync();
    cp_event = 1'b1;
    write(1'b1, 1'b1);
    cp_event = 1'b0;
    chk("R3 pending, same-cycle event ignored", {2'b00, pd_active, pd_pending}, 4'b0001);
    edge1(); edge1();
    chk("R3 waits for event", {2'b00, pd_active, pd_pending}, 4'b0001);
    cp_event = 1'b1;
    edge1();
    cp_event = 1'b0;
    chk("R4 event entry", {2'b00, pd_active, pd_pending}, 4'b0010);
    write(1'b0, 1'b1);
    chk("R9 exit after sync", {3'b000, pd_active}, 4'b0000);
  endtask

  task automatic t_cancel();
    write(1'b1, 1'b1);
    chk("R8 pending before cancel", {3'b000, pd_pending}, 4'b0001);
    write(1'b0, 1'b1);
    chk("R8 cancelled", {2'b00, pd_active, pd_pending}, 4'b0000);
    cp_event = 1'b1;
    edge1();
    cp_event = 1'b0;
    edge1();
    chk("R8 late event no effect", {2'b00, pd_active, pd_pending}, 4'b0000);
  endtask

  task automatic t_init();
    init_pulse = 1'b1;
    write(1'b1, 1'b1);
    init_pulse = 1'b0;
    chk("R7 init pulse entry", {2'b00, pd_active, pd_pending}, 4'b0010);
    write(1'b0, 1'b0);
    write(1'b1, 1'b1);
    init_pulse = 1'b1;
    edge1();
    init_pulse = 1'b0;
    chk("R7 init from pending", {2'b00, pd_active, pd_pending}, 4'b0010);
    write(1'b0, 1'b0);
    chk("R7 cleanup", {3'b000, pd_active}, 4'b0000);
  endtask

  task automatic t_ce_low();
    edge1();
    chip_en = 1'b0;
    #1;
    chk("R1 immediate", {pd_active, force_load, cp_tristate, clkdet_reset}, 4'b1111);
    edge1();
    write(1'b1, 1'b0);
    chk("R6 write while down", {2'b00, pd_en_q, pd_sync_q}, 4'b0010);
    write(1'b0, 1'b1);
    chk("R6 second write", {2'b00, pd_en_q, pd_sync_q}, 4'b0001);
    chk("R1 still down", {3'b000, pd_active}, 4'b0001);
    release_ce();
    edge1();
    chk("R9 resumes after ce", {2'b00, pd_active, pd_pending}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_ce_rise();
    t_idle_cp();
    t_async();
    t_sync();
    t_cancel();
    t_init();
    t_ce_low();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule